// File: doc/BRIEF.md
# Downward-Growing Hardware Stack Pointer

This block holds the stack pointer of a small processor core and turns stack operations into byte accesses on a single-port data memory. The stack grows toward lower addresses. A push stores a byte at the address the pointer holds and then moves the pointer down by one. A pop first moves the pointer up by one and then reads at the new address. Single data bytes move the pointer by one. Return addresses, which are pushed by calls and interrupt entry and popped by returns, span two bytes and take one cycle per byte. Over the whole operation the pointer moves by two.

Software sees the pointer as two byte-wide halves, and each half has its own write strobe. The full 16-bit value is always visible on an output. A software write that lands in the same cycle as a stack operation decides the pointer value. The memory access of that operation still takes place at the old address. The data memory sits outside the block: the block drives an address, a write enable and write data, and it takes read data back combinationally in the same cycle.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x0000, `op_ready` is 1, and `pop_valid` and `ret_valid` are 0.
- R2: Operation code 1 (byte push), accepted while `op_ready` is 1, writes `push_byte` to the address equal to the pointer and lowers the pointer by 1 at the same clock edge.
- R3: Operation code 2 (byte pop) reads at pointer+1 and raises the pointer by 1. The byte read appears on `pop_byte`, with `pop_valid` high for exactly one cycle, after that edge.
- R4: Operation code 3 (return push) takes two cycles. With starting pointer S, bits 7:0 of `push_ret` are written to S and bits 15:8 to S-1, and the pointer ends at S-2. `op_ready` is 0 during the second cycle.
- R5: Operation code 4 (return pop) takes two cycles. With starting pointer S, the byte at S+1 becomes bits 15:8 and the byte at S+2 becomes bits 7:0. The pointer ends at S+2, and `ret_addr` carries the result with `ret_valid` high for one cycle after the second edge.
- R6: `sw_wr_en` bit 0 loads `sw_wdata` into pointer bits 7:0 and bit 1 loads it into bits 15:8. The other half keeps its value. In a cycle with any software write, the stack operation's pointer step is discarded, but its memory access still happens at the old pointer.
- R7: The pointer wraps modulo 2^16. A push at 0x0000 leaves 0xFFFF, and a pop at 0xFFFF leaves 0x0000.
- R8: Operation codes presented while `op_ready` is 0 are ignored. Codes 0, 5, 6 and 7 do nothing: no memory write and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Stack operation: 0 none, 1 byte push, 2 byte pop, 3 return push, 4 return pop |
| op_ready | output | 1 | High when a new operation is accepted |
| push_byte | input | 8 | Data byte for a byte push |
| push_ret | input | 16 | Return address for a return push |
| sw_wr_en | input | 2 | Software write strobes: bit 0 low half, bit 1 high half |
| sw_wdata | input | 8 | Software write data |
| sp_value | output | 16 | Current pointer value |
| mem_addr | output | 16 | Data memory byte address |
| mem_we | output | 1 | Data memory write enable |
| mem_wdata | output | 8 | Data memory write data |
| mem_rdata | input | 8 | Data memory read data, same cycle as the address |
| pop_byte | output | 8 | Byte returned by the last byte pop |
| pop_valid | output | 1 | One-cycle strobe marking `pop_byte` valid |
| ret_addr | output | 16 | Address returned by a return pop |
| ret_valid | output | 1 | One-cycle strobe marking `ret_addr` valid |

## Verification
A byte push or pop changes `sp_value` and the memory contents at the clock edge that accepts it, and `pop_valid` rises after that same edge. A return push or pop finishes one edge later, and `ret_valid` is high only in the cycle after that second edge. The bench drives inputs on the falling edge. It checks each result at the falling edge that follows the edge where the result is due, and for return pops it also checks one cycle later that `ret_valid` has dropped. The sweeps push and pop long runs of distinct bytes and return addresses, so that every value the bench predicts by arithmetic is tied to a single address.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_PUSH_BYTE = 3'd1,
        OP_POP_BYTE  = 3'd2,
        OP_PUSH_RET  = 3'd3,
        OP_POP_RET   = 3'd4
    } stk_op_e;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_RET_PUSH = 2'd1,
        PH_RET_POP  = 2'd2
    } seq_phase_e;

endpackage

// File: rtl/sp_pointer_reg.sv
module sp_pointer_reg #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step_en,
    input  logic                       step_up,
    input  logic [ADDR_W/BYTE_W-1:0]   sw_wr,
    input  logic [BYTE_W-1:0]          sw_wdata,
    output logic [ADDR_W-1:0]          sp_q
);
    localparam int HALVES = ADDR_W / BYTE_W;

    logic [ADDR_W-1:0] sp_d;
    logic [ADDR_W-1:0] stepped;
    logic              any_sw;

    always_comb begin
        stepped = step_up ? sp_q + ADDR_W'(1) : sp_q - ADDR_W'(1);
        any_sw  = |sw_wr;
    end

    for (genvar g = 0; g < HALVES; g++) begin : g_half
        assign sp_d[g*BYTE_W +: BYTE_W] =
            sw_wr[g]  ? sw_wdata :
            any_sw    ? sp_q[g*BYTE_W +: BYTE_W] :
            step_en   ? stepped[g*BYTE_W +: BYTE_W] :
                        sp_q[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && sw_wr == '0) |=> sp_q == $past(sp_q) - ADDR_W'(1));

    assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && sw_wr == '0) |=> sp_q == $past(sp_q) + ADDR_W'(1));

    assert_sw_low_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr[0] && !sw_wr[HALVES-1]) |=>
            (sp_q[BYTE_W-1:0] == $past(sw_wdata)) &&
            (sp_q[ADDR_W-1:ADDR_W-BYTE_W] == $past(sp_q[ADDR_W-1:ADDR_W-BYTE_W])));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && sw_wr == '0) |=> $stable(sp_q));

endmodule

// File: rtl/sp_access_seq.sv
module sp_access_seq
    import stack_ptr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op,
    input  logic [BYTE_W-1:0] push_byte,
    input  logic [ADDR_W-1:0] push_ret,
    input  logic [ADDR_W-1:0] sp_cur,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              ready,
    output logic              step_en,
    output logic              step_up,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [BYTE_W-1:0] pop_byte,
    output logic              pop_valid,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              ret_valid
);
    localparam int HALVES = ADDR_W / BYTE_W;
    localparam int CW     = $clog2(HALVES + 1);
    localparam logic [CW-1:0] LAST = CW'(HALVES - 1);

    typedef struct packed {
        seq_phase_e        phase;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] shreg;
        logic [BYTE_W-1:0] pop_byte;
        logic              pop_valid;
        logic              ret_valid;
    } seq_state_t;

    seq_state_t cur_q, nxt_d;
    logic [ADDR_W-1:0] sp_plus;

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.pop_valid = 1'b0;
        nxt_d.ret_valid = 1'b0;
        sp_plus         = sp_cur + ADDR_W'(1);
        ready           = (cur_q.phase == PH_IDLE);
        step_en         = 1'b0;
        step_up         = 1'b0;
        mem_we          = 1'b0;
        mem_wdata       = '0;
        mem_addr        = sp_plus;
        unique case (cur_q.phase)
            PH_IDLE: begin
                case (op)
                    OP_PUSH_BYTE: begin
                        mem_we    = 1'b1;
                        mem_addr  = sp_cur;
                        mem_wdata = push_byte;
                        step_en   = 1'b1;
                    end
                    OP_POP_BYTE: begin
                        step_en         = 1'b1;
                        step_up         = 1'b1;
                        nxt_d.pop_byte  = mem_rdata;
                        nxt_d.pop_valid = 1'b1;
                    end
                    OP_PUSH_RET: begin
                        mem_we      = 1'b1;
                        mem_addr    = sp_cur;
                        mem_wdata   = push_ret[BYTE_W-1:0];
                        step_en     = 1'b1;
                        nxt_d.shreg = push_ret >> BYTE_W;
                        nxt_d.cnt   = CW'(1);
                        nxt_d.phase = PH_RET_PUSH;
                    end
                    OP_POP_RET: begin
                        step_en     = 1'b1;
                        step_up     = 1'b1;
                        nxt_d.shreg = ADDR_W'(mem_rdata);
                        nxt_d.cnt   = CW'(1);
                        nxt_d.phase = PH_RET_POP;
                    end
                    default: ;
                endcase
            end
            PH_RET_PUSH: begin
                mem_we      = 1'b1;
                mem_addr    = sp_cur;
                mem_wdata   = cur_q.shreg[BYTE_W-1:0];
                step_en     = 1'b1;
                nxt_d.shreg = cur_q.shreg >> BYTE_W;
                nxt_d.cnt   = cur_q.cnt + CW'(1);
                if (cur_q.cnt == LAST) begin
                    nxt_d.cnt   = '0;
                    nxt_d.phase = PH_IDLE;
                end
            end
            PH_RET_POP: begin
                step_en     = 1'b1;
                step_up     = 1'b1;
                nxt_d.shreg = {cur_q.shreg[ADDR_W-BYTE_W-1:0], mem_rdata};
                nxt_d.cnt   = cur_q.cnt + CW'(1);
                if (cur_q.cnt == LAST) begin
                    nxt_d.cnt       = '0;
                    nxt_d.phase     = PH_IDLE;
                    nxt_d.ret_valid = 1'b1;
                end
            end
            default: nxt_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.phase <= PH_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pop_byte  = cur_q.pop_byte;
    assign pop_valid = cur_q.pop_valid;
    assign ret_addr  = cur_q.shreg;
    assign ret_valid = cur_q.ret_valid;

    assert_ret_push_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op == OP_PUSH_RET) |=> (!ready && mem_we));

    assert_ret_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> !ret_valid);

    assert_pop_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> $past(ready));

    assert_ret_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> !$past(ready));

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stack_ptr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               op_code,
    output logic                     op_ready,
    input  logic [BYTE_W-1:0]        push_byte,
    input  logic [ADDR_W-1:0]        push_ret,
    input  logic [ADDR_W/BYTE_W-1:0] sw_wr_en,
    input  logic [BYTE_W-1:0]        sw_wdata,
    output logic [ADDR_W-1:0]        sp_value,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_we,
    output logic [BYTE_W-1:0]        mem_wdata,
    input  logic [BYTE_W-1:0]        mem_rdata,
    output logic [BYTE_W-1:0]        pop_byte,
    output logic                     pop_valid,
    output logic [ADDR_W-1:0]        ret_addr,
    output logic                     ret_valid
);
    stk_op_e op_e;
    logic    step_en;
    logic    step_up;

    assign op_e = stk_op_e'(op_code);

    sp_pointer_reg #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .step_up  (step_up),
        .sw_wr    (sw_wr_en),
        .sw_wdata (sw_wdata),
        .sp_q     (sp_value)
    );

    sp_access_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op_e),
        .push_byte (push_byte),
        .push_ret  (push_ret),
        .sp_cur    (sp_value),
        .mem_rdata (mem_rdata),
        .ready     (op_ready),
        .step_en   (step_en),
        .step_up   (step_up),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .pop_byte  (pop_byte),
        .pop_valid (pop_valid),
        .ret_addr  (ret_addr),
        .ret_valid (ret_valid)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (sp_value == '0 && op_ready && !pop_valid && !ret_valid));

endmodule

// File: tb/sim_stack_ptr_unit.sv
module sim_stack_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic        op_ready;
    logic [7:0]  push_byte = 8'd0;
    logic [15:0] push_ret = 16'd0;
    logic [1:0]  sw_wr_en = 2'b00;
    logic [7:0]  sw_wdata = 8'd0;
    logic [15:0] sp_value;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [7:0]  pop_byte;
    logic        pop_valid;
    logic [15:0] ret_addr;
    logic        ret_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp_sp = 0;

    logic [7:0] mem [256];

    always #5 clk = ~clk;

    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[7:0]];

    stack_ptr_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_ready(op_ready),
        .push_byte(push_byte), .push_ret(push_ret), .sw_wr_en(sw_wr_en),
        .sw_wdata(sw_wdata), .sp_value(sp_value), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pop_byte(pop_byte), .pop_valid(pop_valid), .ret_addr(ret_addr),
        .ret_valid(ret_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [1:0] wr, input logic [7:0] d);
        sw_wr_en = wr; sw_wdata = d;
        @(negedge clk);
        sw_wr_en = 2'b00;
        if (wr[0]) exp_sp = (exp_sp & 16'hFF00) | d;
        if (wr[1]) exp_sp = (exp_sp & 16'h00FF) | (int'(d) << 8);
    endtask

    task automatic push_b(input logic [7:0] d);
        int s = exp_sp;
        op_code = 3'd1; push_byte = d;
        @(negedge clk);
        op_code = 3'd0;
        exp_sp = (s - 1) & 16'hFFFF;
        chk(sp_value == 16'(exp_sp), "R2 pointer after push", sp_value, exp_sp);
        chk(mem[s & 8'hFF] == d, "R2 byte stored at old pointer", mem[s & 8'hFF], d);
    endtask

    task automatic pop_b(input logic [7:0] exp_d);
        op_code = 3'd2;
        @(negedge clk);
        op_code = 3'd0;
        exp_sp = (exp_sp + 1) & 16'hFFFF;
        chk(sp_value == 16'(exp_sp), "R3 pointer after pop", sp_value, exp_sp);
        chk(pop_valid && pop_byte == exp_d, "R3 popped byte", pop_byte, exp_d);
    endtask

    task automatic push_r(input logic [15:0] a);
        int s = exp_sp;
        op_code = 3'd3; push_ret = a;
        @(negedge clk);
        op_code = 3'd2;
        chk(op_ready == 1'b0, "R4 busy in second cycle", op_ready, 0);
        @(negedge clk);
        op_code = 3'd0;
        exp_sp = (s - 2) & 16'hFFFF;
        chk(sp_value == 16'(exp_sp), "R4/R8 pointer after return push", sp_value, exp_sp);
        chk(pop_valid == 1'b0, "R8 pop during busy ignored", pop_valid, 0);
        chk(mem[s & 8'hFF] == a[7:0], "R4 low byte at S", mem[s & 8'hFF], a[7:0]);
        chk(mem[(s - 1) & 8'hFF] == a[15:8], "R4 high byte at S-1",
            mem[(s - 1) & 8'hFF], a[15:8]);
    endtask

    task automatic pop_r(input logic [15:0] exp_a);
        int s = exp_sp;
        op_code = 3'd4;
        @(negedge clk);
        op_code = 3'd1; push_byte = 8'hEE;
        @(negedge clk);
        op_code = 3'd0;
        exp_sp = (s + 2) & 16'hFFFF;
        chk(sp_value == 16'(exp_sp), "R5/R8 pointer after return pop", sp_value, exp_sp);
        chk(ret_valid && ret_addr == exp_a, "R5 returned address", ret_addr, exp_a);
        @(negedge clk);
        chk(ret_valid == 1'b0, "R5 valid is one cycle", ret_valid, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp_value == 16'h0000, "R1 pointer reset", sp_value, 0);
        chk(op_ready && !pop_valid && !ret_valid, "R1 idle outputs",
            {op_ready, pop_valid, ret_valid}, 3'b100);

        sw_write(2'b01, 8'h80);
        chk(sp_value == 16'h0080, "R6 low half write", sp_value, 16'h0080);
        sw_write(2'b10, 8'h3C);
        chk(sp_value == 16'h3C80, "R6 high half write keeps low", sp_value, 16'h3C80);
        sw_write(2'b10, 8'h00);
        chk(sp_value == 16'h0080, "R6 high half rewrite", sp_value, 16'h0080);

        for (int i = 0; i < 40; i++) push_b(8'((i * 37 + 5) & 8'hFF));
        for (int i = 39; i >= 0; i--) pop_b(8'((i * 37 + 5) & 8'hFF));

        sw_write(2'b01, 8'hF0);
        for (int i = 0; i < 8; i++) push_r(16'(i * 16'h1111 + 16'h0203));
        for (int i = 7; i >= 0; i--) pop_r(16'(i * 16'h1111 + 16'h0203));

        for (int c = 5; c < 8; c++) begin
            op_code = 3'(c); push_byte = 8'h99;
            @(negedge clk);
            op_code = 3'd0;
            chk(sp_value == 16'(exp_sp), "R8 undefined code ignored", sp_value, exp_sp);
            chk(mem[exp_sp & 8'hFF] != 8'h99, "R8 undefined code no write",
                mem[exp_sp & 8'hFF], 0);
        end
        op_code = 3'd0;
        @(negedge clk);
        chk(sp_value == 16'(exp_sp), "R8 code 0 no change", sp_value, exp_sp);

        sw_write(2'b01, 8'h00);
        chk(sp_value == 16'h0000, "R7 set pointer to zero", sp_value, 0);
        push_b(8'hA5);
        chk(sp_value == 16'hFFFF, "R7 wrap down", sp_value, 16'hFFFF);
        pop_b(8'hA5);
        chk(sp_value == 16'h0000, "R7 wrap up", sp_value, 0);
        sw_write(2'b01, 8'h01);
        push_r(16'hBEEF);
        chk(sp_value == 16'hFFFF, "R7 return push across zero", sp_value, 16'hFFFF);
        pop_r(16'hBEEF);

        sw_write(2'b11, 8'h00);
        sw_write(2'b01, 8'h50);
        op_code = 3'd1; push_byte = 8'h6B;
        sw_wr_en = 2'b01; sw_wdata = 8'h33;
        @(negedge clk);
        op_code = 3'd0; sw_wr_en = 2'b00;
        exp_sp = 16'h0033;
        chk(sp_value == 16'h0033, "R6 software write wins", sp_value, 16'h0033);
        chk(mem[8'h50] == 8'h6B, "R6 access at old pointer", mem[8'h50], 8'h6B);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule